// File: doc/BRIEF.md
# Push-Button Power Sequencer

This block decides when a board's power regulators are enabled. It reads an active-low push button, a power-good level, a strap, and an active-low kill request from the processor's power-management unit. It drives a regulator enable and an active-high shutdown interrupt toward that processor. Each button press is synchronized, debounced, and classified as short or long by how long its debounced level stays low.

While power is off, the release of any press turns the regulators on. While power is on, a short press leaves the rails up and raises the interrupt, and the rails stay up until the processor answers with kill. A long press raises the interrupt for a fixed grace window and then removes power whether or not kill ever arrives. After any power-down, the button must be released before a new press counts, so a long press that is still held cannot turn the board straight back on. A strap chooses between waiting for a press and powering up as soon as power-good rises.

Top module: `pb_power_seq`

## Requirements
- R1: A button level change that lasts fewer than DEBOUNCE_CYCLES clocks after synchronization is ignored. A glitch while off leaves rail_en low.
- R2: While off, the debounced release of a press turns rail_en high, whatever the press length was.
- R3: While on, a press released before LONG_PRESS_CYCLES of debounced hold raises pwr_irq and keeps rail_en high.
- R4: While on, or while a shutdown request is pending, a press held for LONG_PRESS_CYCLES raises pwr_irq with rail_en still high for FORCE_HOLD_CYCLES clocks. After that window rail_en goes low without any kill.
- R5: kill_n low while rail_en is high drops rail_en in the same cycle. rail_en stays low after kill_n returns high.
- R6: kill_n is ignored while rail_en is low. A later press still powers up.
- R7: With strap_auto_on low, the block stays off after reset or after pgood rises. With it high, rail_en goes high within two clocks of reset release or of pgood rising.
- R8: pwr_irq is never high while rail_en is low. Once raised, it stays high until power is removed, including across further short presses.
- R9: After a power-down, the block stays off while the button is still held. The release of that press does not power up.
- R10: pgood low drops rail_en and pwr_irq at once and returns the block to the off state.
- R11: During reset, rail_en and pwr_irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Push button, low while pressed, asynchronous |
| kill_n | input | 1 | Power-off request from the processor, active low |
| pgood | input | 1 | Input power valid, active high |
| strap_auto_on | input | 1 | 1: power up when pgood rises; 0: wait for a press |
| rail_en | output | 1 | Regulator enable, active high |
| pwr_irq | output | 1 | Shutdown interrupt to the processor, active high |

## Verification
A state machine stuck in the wrong state shows up on rail_en and pwr_irq within a few debounce windows of the next press. Examples are rails that stay up after a long press, an interrupt with no rails, or a power-up triggered by the release that follows a forced shutdown. Press-length errors in the timer move the forced-off point, and a window sample placed inside the grace period detects this to within a few cycles. Kill and power-good loss are combinational paths, so a fault there is visible in the same cycle as the input change.

// File: rtl/pbps_pkg.sv
package pbps_pkg;

   typedef enum logic [2:0] {
      PS_OFF      = 3'd0,
      PS_WAIT_REL = 3'd1,
      PS_ON       = 3'd2,
      PS_SHUT_REQ = 3'd3,
      PS_FORCED   = 3'd4
   } pwr_state_e;

endpackage

// File: rtl/pbps_debounce.sv
module pbps_debounce #(
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned DEBOUNCE_CYCLES = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_n,
   output logic pressed
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], ~btn_n};
   end

   assign raw = sync_q[SYNC_STAGES-1];

   generate
      if (DEBOUNCE_CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pressed <= 1'b0;
            else        pressed <= raw;
         end
      end else begin : g_counted
         localparam int unsigned DW = $clog2(DEBOUNCE_CYCLES);
         localparam logic [DW-1:0] DEB_LAST = DW'(DEBOUNCE_CYCLES - 1);
         logic [DW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pressed <= 1'b0;
               cnt_q   <= '0;
            end else if (raw != pressed) begin
               if (cnt_q == DEB_LAST) begin
                  pressed <= raw;
                  cnt_q   <= '0;
               end else begin
                  cnt_q   <= cnt_q + 1'b1;
               end
            end else begin
               cnt_q <= '0;
            end
         end

         AST_DEB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (raw != pressed && cnt_q != DEB_LAST) |=> $stable(pressed)); // R1
      end
   endgenerate

endmodule

// File: rtl/pbps_press_timer.sv
module pbps_press_timer #(
   parameter int unsigned LONG_PRESS_CYCLES = 500_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pressed,
   output logic rel_evt,
   output logic short_rel,
   output logic long_evt
);

   localparam int unsigned HW = $clog2(LONG_PRESS_CYCLES + 1);
   localparam logic [HW-1:0] HOLD_MAX  = HW'(LONG_PRESS_CYCLES);
   localparam logic [HW-1:0] HOLD_EDGE = HW'(LONG_PRESS_CYCLES - 1);

   logic          pressed_d;
   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pressed_d <= 1'b0;
         hold_q    <= '0;
      end else begin
         pressed_d <= pressed;
         if (!pressed)              hold_q <= '0;
         else if (hold_q != HOLD_MAX) hold_q <= hold_q + 1'b1;
      end
   end

   assign rel_evt   = pressed_d & ~pressed;
   assign short_rel = rel_evt & (hold_q != HOLD_MAX);
   assign long_evt  = pressed & (hold_q == HOLD_EDGE);

   AST_LONG_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      long_evt |=> !long_evt); // R4

   AST_REL_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      long_evt |-> !rel_evt); // R3

endmodule

// File: rtl/pbps_fsm.sv
module pbps_fsm
   import pbps_pkg::*;
#(
   parameter int unsigned FORCE_HOLD_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pressed,
   input  logic rel_evt,
   input  logic short_rel,
   input  logic long_evt,
   input  logic kill_n,
   input  logic pgood,
   input  logic strap_auto_on,
   output logic rail_en,
   output logic pwr_irq
);

   localparam int unsigned FW = $clog2(FORCE_HOLD_CYCLES);
   localparam logic [FW-1:0] FORCE_LAST = FW'(FORCE_HOLD_CYCLES - 1);

   pwr_state_e    state_q, state_d;
   logic          pg_q;
   logic [FW-1:0] fcnt_q;
   logic          on_q, irq_q;

   always_comb begin
      state_d = state_q;
      if (!pgood) begin
         state_d = PS_OFF;
      end else begin
         unique case (state_q)
            PS_OFF: begin
               if (strap_auto_on && !pg_q) state_d = PS_ON;
               else if (rel_evt)           state_d = PS_ON;
            end
            PS_WAIT_REL: if (!pressed) state_d = PS_OFF;
            PS_ON: begin
               if (!kill_n)        state_d = PS_WAIT_REL;
               else if (long_evt)  state_d = PS_FORCED;
               else if (short_rel) state_d = PS_SHUT_REQ;
            end
            PS_SHUT_REQ: begin
               if (!kill_n)       state_d = PS_WAIT_REL;
               else if (long_evt) state_d = PS_FORCED;
            end
            PS_FORCED: begin
               if (!kill_n || fcnt_q == FORCE_LAST) state_d = PS_WAIT_REL;
            end
            default: state_d = PS_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_OFF;
         pg_q    <= 1'b0;
         fcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         pg_q    <= pgood;
         if (state_q == PS_FORCED) fcnt_q <= fcnt_q + 1'b1;
         else                      fcnt_q <= '0;
      end
   end

   assign on_q    = (state_q == PS_ON) || (state_q == PS_SHUT_REQ) || (state_q == PS_FORCED);
   assign irq_q   = (state_q == PS_SHUT_REQ) || (state_q == PS_FORCED);
   assign rail_en = on_q  & kill_n & pgood;
   assign pwr_irq = irq_q & kill_n & pgood;

   AST_KILL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q && !kill_n) |=> !rail_en); // R5

   AST_SHORT_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_ON && short_rel && kill_n && pgood) |=> (state_q == PS_SHUT_REQ)); // R3

   AST_LONG_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == PS_ON || state_q == PS_SHUT_REQ) && long_evt && kill_n && pgood)
      |=> (state_q == PS_FORCED)); // R4

   AST_FORCE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_FORCED && fcnt_q == FORCE_LAST) |=> !on_q); // R4

   AST_HELD_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_WAIT_REL && pressed) |=> !rail_en); // R9

   AST_PG_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !pgood |=> (state_q == PS_OFF)); // R10

endmodule

// File: rtl/pb_power_seq.sv
module pb_power_seq #(
   parameter int unsigned SYNC_STAGES       = 2,
   parameter int unsigned DEBOUNCE_CYCLES   = 1_000_000,
   parameter int unsigned LONG_PRESS_CYCLES = 500_000_000,
   parameter int unsigned FORCE_HOLD_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_n,
   input  logic kill_n,
   input  logic pgood,
   input  logic strap_auto_on,
   output logic rail_en,
   output logic pwr_irq
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DEBOUNCE_CYCLES < 1) begin : g_bad_deb
         $error("DEBOUNCE_CYCLES must be at least 1");
      end
      if (LONG_PRESS_CYCLES < 2 * DEBOUNCE_CYCLES + 2) begin : g_bad_long
         $error("LONG_PRESS_CYCLES must exceed twice the debounce window");
      end
      if (FORCE_HOLD_CYCLES < 2) begin : g_bad_force
         $error("FORCE_HOLD_CYCLES must be at least 2");
      end
   endgenerate

   logic pressed, rel_evt, short_rel, long_evt;

   pbps_debounce #(
      .SYNC_STAGES     (SYNC_STAGES),
      .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
   ) i_debounce (
      .clk     (clk),
      .rst_n   (rst_n),
      .btn_n   (btn_n),
      .pressed (pressed)
   );

   pbps_press_timer #(
      .LONG_PRESS_CYCLES (LONG_PRESS_CYCLES)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .pressed   (pressed),
      .rel_evt   (rel_evt),
      .short_rel (short_rel),
      .long_evt  (long_evt)
   );

   pbps_fsm #(
      .FORCE_HOLD_CYCLES (FORCE_HOLD_CYCLES)
   ) i_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .pressed       (pressed),
      .rel_evt       (rel_evt),
      .short_rel     (short_rel),
      .long_evt      (long_evt),
      .kill_n        (kill_n),
      .pgood         (pgood),
      .strap_auto_on (strap_auto_on),
      .rail_en       (rail_en),
      .pwr_irq       (pwr_irq)
   );

   AST_IRQ_NEEDS_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_irq |-> rail_en); // R8

endmodule

// File: tb/test_pb_power_seq.sv
module test_pb_power_seq;

   localparam int unsigned DEB   = 4;
   localparam int unsigned LONG  = 60;
   localparam int unsigned FORCE = 8;

   localparam int M_OFF = 0;
   localparam int M_ON  = 1;
   localparam int M_REQ = 2;

   logic clk = 1'b0;
   logic rst_n, btn_n, kill_n, pgood, strap_auto_on;
   logic rail_en, pwr_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pb_power_seq #(
      .SYNC_STAGES       (2),
      .DEBOUNCE_CYCLES   (DEB),
      .LONG_PRESS_CYCLES (LONG),
      .FORCE_HOLD_CYCLES (FORCE)
   ) i_pb_power_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .btn_n         (btn_n),
      .kill_n        (kill_n),
      .pgood         (pgood),
      .strap_auto_on (strap_auto_on),
      .rail_en       (rail_en),
      .pwr_irq       (pwr_irq)
   );

   function automatic int model_next(int st, int op);
      // op 0: short press, 1: long press, 2: kill pulse
      case (st)
         M_OFF:   return (op == 2) ? M_OFF : M_ON;
         M_ON:    return (op == 0) ? M_REQ : M_OFF;
         default: return (op == 0) ? M_REQ : M_OFF;
      endcase
   endfunction

   function automatic logic model_rail(int st);
      return st != M_OFF;
   endfunction

   function automatic logic model_irq(int st);
      return st == M_REQ;
   endfunction

   task automatic chk(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press(int len);
      btn_n = 1'b0;
      cyc(len);
      btn_n = 1'b1;
      cyc(25);
   endtask

   task automatic kill_pulse();
      kill_n = 1'b0;
      cyc(3);
      kill_n = 1'b1;
      cyc(25);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cyc(4);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int st;
      int op;
      btn_n = 1'b1; kill_n = 1'b1; pgood = 1'b1; strap_auto_on = 1'b0; rst_n = 1'b0;
      cyc(4);
      chk("R11 rail in reset", rail_en, 1'b0);
      chk("R11 irq in reset", pwr_irq, 1'b0);
      rst_n = 1'b1;
      cyc(10);
      chk("R7 strap low stays off", rail_en, 1'b0);

      // R1: a short glitch is filtered
      btn_n = 1'b0; cyc(2); btn_n = 1'b1; cyc(20);
      chk("R1 glitch ignored", rail_en, 1'b0);

      // R2: press from off powers up
      press(20);
      chk("R2 power up", rail_en, 1'b1);
      chk("R8 no irq when on", pwr_irq, 1'b0);

      // R3: short press requests shutdown
      press(20);
      chk("R3 rail kept", rail_en, 1'b1);
      chk("R3 irq raised", pwr_irq, 1'b1);
      press(15);
      chk("R8 irq holds", pwr_irq, 1'b1);

      // R5: kill drops power at once
      kill_n = 1'b0;
      #1;
      chk("R5 same cycle", rail_en, 1'b0);
      chk("R8 irq cleared", pwr_irq, 1'b0);
      cyc(3);
      kill_n = 1'b1;
      cyc(10);
      chk("R5 stays off", rail_en, 1'b0);

      // R6: kill while off ignored
      kill_pulse();
      chk("R6 kill off", rail_en, 1'b0);
      press(20);
      chk("R6 press after kill", rail_en, 1'b1);

      // R4 and R9: long press forces off
      btn_n = 1'b0;
      cyc(69);
      chk("R4 grace rail", rail_en, 1'b1);
      chk("R4 grace irq", pwr_irq, 1'b1);
      cyc(21);
      chk("R4 forced off", rail_en, 1'b0);
      cyc(200);
      chk("R9 held stays off", rail_en, 1'b0);
      btn_n = 1'b1;
      cyc(30);
      chk("R9 release no power up", rail_en, 1'b0);

      // R7 and R10: strap and power-good
      strap_auto_on = 1'b1;
      do_reset();
      cyc(3);
      chk("R7 auto on after reset", rail_en, 1'b1);
      pgood = 1'b0;
      #1;
      chk("R10 pgood loss", rail_en, 1'b0);
      cyc(5);
      pgood = 1'b1;
      cyc(3);
      chk("R7 auto on at pgood", rail_en, 1'b1);
      strap_auto_on = 1'b0;
      pgood = 1'b0;
      cyc(5);
      pgood = 1'b1;
      cyc(5);
      chk("R10 off after pgood return", rail_en, 1'b0);
      chk("R10 irq off", pwr_irq, 1'b0);

      // constrained random sequence against the model
      void'($urandom(32'd2024));
      do_reset();
      cyc(5);
      st = M_OFF;
      for (int i = 0; i < 40; i++) begin
         case ($urandom % 4)
            0, 1: begin op = 0; press(10 + int'($urandom % 31)); end
            2:    begin op = 1; press(100 + int'($urandom % 40)); end
            default: begin op = 2; kill_pulse(); end
         endcase
         st = model_next(st, op);
         chk("R2 R3 R4 R5 random rail", rail_en, model_rail(st));
         chk("R3 R8 random irq", pwr_irq, model_irq(st));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule